// File: doc/BRIEF.md
# Open-Page DDR Command Scheduler

This block sits between a memory requester and the command pins of a DDR SDRAM array. It takes read, write and precharge requests and turns them into ACTIVATE, column READ/WRITE, PRECHARGE, precharge-all, AUTO REFRESH and self-refresh entry/exit commands, one command slot per clock. For each bank it remembers whether a row is open and which row that is. An access that names the open row of its bank goes straight to a column command. The block never closes a row to make room for another. A row stays open until the requester asks for a precharge of that bank, or until a refresh or self-refresh entry needs every bank closed.

Requests enter a two-slot queue, so the next request is taken while the current one is still waiting on a timer or on its burst. Back-to-back page hits therefore leave the bus with no empty command slots between bursts. Row-to-column delay, precharge time, refresh recovery, burst length and refresh interval sit in registers. These registers hold defaults after reset and can be rewritten at any time through a small write port. Down-counters enforce every gap.

Top module: `dps_sched`

## Requirements
- R1: A read or write to a bank with no open row issues ACTIVATE (cmd_code 1) carrying the row on cmd_addr, then the column command exactly t_rcd cycles later, carrying the column in the low bits of cmd_addr.
- R2: A read or write whose row equals the open row of its bank issues READ (code 2) or WRITE (code 3) with no ACTIVATE; open rows of different banks are tracked independently.
- R3: An access to an open bank holding a different row issues no command and holds miss_flag high; a precharge request (req_op 2) for that bank queued behind it is issued first as PRECHARGE (code 4), then ACTIVATE follows exactly t_rp cycles later, and miss_flag falls.
- R4: PRECHARGE appears only for a user precharge request naming an open bank; a precharge request to a closed bank is consumed with no command.
- R5: Consecutive page-hit column commands are spaced exactly by the burst gap, where burst code 0, 1, 2 (burst 2, 4, 8) gives a gap of 1, 2, 4 cycles, with no idle slot between them.
- R6: Timing registers reset to t_rcd=3, t_rp=3, t_rfc=8, burst code 1 and refresh interval 1200, and are written with cfg_we at index 0 (t_rcd), 1 (t_rp), 2 (t_rfc), 3 (burst code), 4 (refresh interval, which also restarts the refresh timer); the new values govern later commands.
- R7: When the refresh interval expires, the block issues precharge-all (code 5) if any row is open, then AUTO REFRESH (code 6) exactly t_rp cycles later; every row is closed afterwards and no command follows REFRESH sooner than t_rfc cycles.
- R8: Raising sleep_req closes all rows (precharge-all) and issues self-refresh entry (code 7), setting in_self_refresh; while set, only NOP (code 0) is driven; lowering sleep_req issues self-refresh exit (code 8) and the next ACTIVATE comes exactly t_rfc cycles after it.
- R9: During and right after reset cmd_code is NOP, req_ready is high, miss_flag and in_self_refresh are low.
- R10: A page-hit request accepted at a clock edge, with no timer pending, has its column command on the bus after the following edge.
- R11: Two requests can be held at once; with both slots full and neither able to issue, req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_op | input | 2 | 0 read, 1 write, 2 precharge, 3 treated as read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_idx | input | 3 | Timing register index |
| cfg_wdata | input | 16 | Timing register value |
| sleep_req | input | 1 | High requests self-refresh, low requests exit |
| cmd_code | output | 4 | Command code (0 NOP .. 8 self-refresh exit) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ROW_W | Row for ACTIVATE, column for READ/WRITE |
| miss_flag | output | 1 | Head request targets a different open row |
| in_self_refresh | output | 1 | Memory is in self-refresh |

## Verification
Each command is registered, so a request taken at one edge shows its first command after the next edge. The bench logs every non-NOP command with the clock count at the falling edge and compares it with the acceptance count plus one. Timer-governed results land a fixed number of cycles after the command that started the timer: t_rcd after ACTIVATE, t_rp after a precharge, t_rfc after REFRESH or self-refresh exit, and the burst gap between column commands. The checks therefore compare differences between logged cycle counts with exact programmed values rather than sampling at guessed absolute times. A scoreboard on the same log checks every minimum gap and every PRECHARGE against the precharge requests the bench has sent.

// File: rtl/dps_pkg.sv
// Shared command codes and helpers for the open-page command scheduler.
// Assumes the command bus carries one command per clock.
package dps_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_PREA = 4'd5,
        CMD_REF  = 4'd6,
        CMD_SRE  = 4'd7,
        CMD_SRX  = 4'd8
    } cmd_e;

    localparam logic [1:0] OP_WR  = 2'd1;
    localparam logic [1:0] OP_PRE = 2'd2;

    // Converts a gap in cycles into a down-counter load value (gap 0 acts as 1).
    function automatic logic [15:0] gap_load(input logic [15:0] gap);
        return (gap == 16'd0) ? 16'd0 : gap - 16'd1;
    endfunction

endpackage

// File: rtl/dps_cfg_regs.sv
// Timing register file. Holds row-to-column delay, precharge time, refresh
// recovery, burst code and refresh interval. Loads defaults at reset and
// takes writes at any time; unknown indices are ignored.
module dps_cfg_regs #(
    parameter int TW       = 16,
    parameter int DEF_RCD  = 3,
    parameter int DEF_RP   = 3,
    parameter int DEF_RFC  = 8,
    parameter int DEF_BL   = 1,
    parameter int DEF_REFI = 1200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    idx,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] t_rcd,
    output logic [TW-1:0] t_rp,
    output logic [TW-1:0] t_rfc,
    output logic [1:0]    bl_code,
    output logic [TW-1:0] ref_ival,
    output logic          ref_restart
);

    // Write decode for the register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_rcd    <= TW'(DEF_RCD);
            t_rp     <= TW'(DEF_RP);
            t_rfc    <= TW'(DEF_RFC);
            bl_code  <= 2'(DEF_BL);
            ref_ival <= TW'(DEF_REFI);
        end else if (we) begin
            case (idx)
                3'd0: t_rcd    <= wdata;
                3'd1: t_rp     <= wdata;
                3'd2: t_rfc    <= wdata;
                3'd3: bl_code  <= wdata[1:0];
                3'd4: ref_ival <= wdata;
                default: ;
            endcase
        end
    end

    // A write to the interval register restarts the refresh timer.
    assign ref_restart = we && (idx == 3'd4);

endmodule

// File: rtl/dps_bank_table.sv
// Open-row table: one valid flag and one row register per bank.
// Assumes set and clear never name the same bank in one cycle.
module dps_bank_table #(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [BANK_W-1:0]           set_bank,
    input  logic [ROW_W-1:0]            set_row,
    input  logic                        clr_en,
    input  logic [BANK_W-1:0]           clr_bank,
    input  logic                        clr_all,
    output logic [NBANK-1:0]            open_vec,
    output logic [NBANK-1:0][ROW_W-1:0] open_row
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic             vld_q;
        logic [ROW_W-1:0] row_q;

        // Tracks whether this bank has a row open and which one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                row_q <= '0;
            end else if (clr_all || (clr_en && clr_bank == BANK_W'(g))) begin
                vld_q <= 1'b0;
            end else if (set_en && set_bank == BANK_W'(g)) begin
                vld_q <= 1'b1;
                row_q <= set_row;
            end
        end

        assign open_vec[g] = vld_q;
        assign open_row[g] = row_q;
    end

endmodule

// File: rtl/dps_refresh_timer.sv
// Refresh interval timer. Counts down and raises a sticky pending flag on
// expiry, reloading from the interval register. Restart loads a new value.
module dps_refresh_timer #(
    parameter int TW       = 16,
    parameter int DEF_REFI = 1200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] ival,
    input  logic          restart,
    input  logic [TW-1:0] restart_val,
    input  logic          done,
    output logic          pending
);

    logic [TW-1:0] cnt_q;

    // Interval down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= TW'(DEF_REFI);
        else if (restart)
            cnt_q <= restart_val;
        else if (cnt_q == '0)
            cnt_q <= ival;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // Pending flag: set on expiry, cleared when the refresh is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (!restart && cnt_q == '0)
            pending <= 1'b1;
        else if (done)
            pending <= 1'b0;
    end

endmodule

// File: rtl/dps_sched.sv
// Open-page DDR command scheduler top. Holds up to two requests, tracks the
// open row of every bank, enforces timing with down-counters and drives one
// registered command per clock. Rows close only on a user precharge, on a
// refresh or on self-refresh entry. Assumes NBANK is a power of two and
// ROW_W >= COL_W.
module dps_sched
    import dps_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int ROW_W    = 13,
    parameter int COL_W    = 10,
    parameter int DEF_RCD  = 3,
    parameter int DEF_RP   = 3,
    parameter int DEF_RFC  = 8,
    parameter int DEF_BL   = 1,
    parameter int DEF_REFI = 1200,
    localparam int BANK_W  = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_idx,
    input  logic [15:0]       cfg_wdata,
    input  logic              sleep_req,
    output logic [3:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              miss_flag,
    output logic              in_self_refresh
);

    localparam int TW = 16;

    typedef struct packed {
        logic [1:0]        op;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } slot_t;

    // Configuration and timers
    logic [TW-1:0] t_rcd, t_rp, t_rfc, ref_ival;
    logic [1:0]    bl_code;
    logic          ref_restart, ref_pend, ref_done;
    logic [TW-1:0] col_gap;
    logic [TW-1:0] w_col, w_rcd, w_bus;

    // Bank table
    logic [NBANK-1:0]            open_vec;
    logic [NBANK-1:0][ROW_W-1:0] open_row;
    logic                        tb_set, tb_clr, tb_clr_all;

    // Request queue
    slot_t s0, s1, s0_n, s1_n, in_req, x;
    logic  v0, v1, v0_n, v1_n, xv;
    logic  miss0, bypass, pop_x, accept;

    // Decision outputs
    cmd_e              nc;
    logic [BANK_W-1:0] nb;
    logic [ROW_W-1:0]  na;
    logic              ld_col, ld_rcd, ld_rp, ld_rfc, sr_set, sr_clr, sr_mode;
    logic              cols_idle, x_open, x_hit, x_pre;

    dps_cfg_regs #(
        .TW(TW), .DEF_RCD(DEF_RCD), .DEF_RP(DEF_RP), .DEF_RFC(DEF_RFC),
        .DEF_BL(DEF_BL), .DEF_REFI(DEF_REFI)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
        .t_rcd(t_rcd), .t_rp(t_rp), .t_rfc(t_rfc), .bl_code(bl_code),
        .ref_ival(ref_ival), .ref_restart(ref_restart)
    );

    dps_refresh_timer #(.TW(TW), .DEF_REFI(DEF_REFI)) u_refi (
        .clk(clk), .rst_n(rst_n), .ival(ref_ival), .restart(ref_restart),
        .restart_val(cfg_wdata), .done(ref_done), .pending(ref_pend)
    );

    dps_bank_table #(.NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .set_en(tb_set), .set_bank(x.bank), .set_row(x.row),
        .clr_en(tb_clr), .clr_bank(x.bank), .clr_all(tb_clr_all),
        .open_vec(open_vec), .open_row(open_row)
    );

    // Burst code to column command spacing in clock cycles.
    always_comb begin
        case (bl_code)
            2'd0:    col_gap = TW'(1);
            2'd1:    col_gap = TW'(2);
            default: col_gap = TW'(4);
        endcase
    end

    // Head selection: a precharge behind a stalled miss to the same bank goes first.
    always_comb begin
        in_req    = '{op: req_op, bank: req_bank, row: req_row, col: req_col};
        miss0     = v0 && (s0.op != OP_PRE) && open_vec[s0.bank]
                    && (open_row[s0.bank] != s0.row);
        bypass    = miss0 && v1 && (s1.op == OP_PRE) && (s1.bank == s0.bank);
        x         = bypass ? s1 : s0;
        xv        = bypass | v0;
        x_open    = open_vec[x.bank];
        x_hit     = x_open && (open_row[x.bank] == x.row);
        x_pre     = (x.op == OP_PRE);
        cols_idle = (w_col == '0) && (w_rcd == '0);
    end

    // Command decision: self-refresh, then refresh/sleep, then the head request.
    always_comb begin
        nc = CMD_NOP; nb = '0; na = '0;
        pop_x = 1'b0; ld_col = 1'b0; ld_rcd = 1'b0; ld_rp = 1'b0; ld_rfc = 1'b0;
        tb_set = 1'b0; tb_clr = 1'b0; tb_clr_all = 1'b0;
        ref_done = 1'b0; sr_set = 1'b0; sr_clr = 1'b0;
        if (sr_mode) begin
            if (!sleep_req && w_bus == '0) begin
                nc = CMD_SRX; sr_clr = 1'b1; ld_rfc = 1'b1;
            end
        end else if (ref_pend || sleep_req) begin
            if (cols_idle && w_bus == '0) begin
                if (|open_vec) begin
                    nc = CMD_PREA; tb_clr_all = 1'b1; ld_rp = 1'b1;
                end else if (ref_pend) begin
                    nc = CMD_REF; ref_done = 1'b1; ld_rfc = 1'b1;
                end else begin
                    nc = CMD_SRE; sr_set = 1'b1;
                end
            end
        end else if (xv) begin
            if (x_pre) begin
                if (!x_open) begin
                    pop_x = 1'b1;
                end else if (cols_idle && w_bus == '0) begin
                    nc = CMD_PRE; nb = x.bank; tb_clr = 1'b1; ld_rp = 1'b1; pop_x = 1'b1;
                end
            end else if (!x_open) begin
                if (w_bus == '0) begin
                    nc = CMD_ACT; nb = x.bank; na = x.row; tb_set = 1'b1; ld_rcd = 1'b1;
                end
            end else if (x_hit && cols_idle) begin
                nc = (x.op == OP_WR) ? CMD_WR : CMD_RD;
                nb = x.bank; na = ROW_W'(x.col); ld_col = 1'b1; pop_x = 1'b1;
            end
        end
    end

    assign req_ready = !v1 || pop_x;
    assign accept    = req_valid && req_ready;
    assign miss_flag = miss0;

    // Queue next state: remove the issued entry, then append the new one.
    always_comb begin
        s0_n = s0; s1_n = s1; v0_n = v0; v1_n = v1;
        if (pop_x && !bypass) begin
            s0_n = s1; v0_n = v1; v1_n = 1'b0;
        end else if (pop_x) begin
            v1_n = 1'b0;
        end
        if (accept) begin
            if (v0_n) begin
                s1_n = in_req; v1_n = 1'b1;
            end else begin
                s0_n = in_req; v0_n = 1'b1;
            end
        end
    end

    // Queue registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v0 <= 1'b0; v1 <= 1'b0; s0 <= '0; s1 <= '0;
        end else begin
            v0 <= v0_n; v1 <= v1_n; s0 <= s0_n; s1 <= s1_n;
        end
    end

    // Timing down-counters: column spacing, row-to-column and bus recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_col <= '0; w_rcd <= '0; w_bus <= '0;
        end else begin
            w_col <= ld_col ? gap_load(col_gap) : (w_col != '0 ? w_col - 1'b1 : '0);
            w_rcd <= ld_rcd ? gap_load(t_rcd)   : (w_rcd != '0 ? w_rcd - 1'b1 : '0);
            if (ld_rp)       w_bus <= gap_load(t_rp);
            else if (ld_rfc) w_bus <= gap_load(t_rfc);
            else if (w_bus != '0) w_bus <= w_bus - 1'b1;
        end
    end

    // Self-refresh mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      sr_mode <= 1'b0;
        else if (sr_set) sr_mode <= 1'b1;
        else if (sr_clr) sr_mode <= 1'b0;
    end

    assign in_self_refresh = sr_mode;

    // Registered command bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code <= CMD_NOP; cmd_bank <= '0; cmd_addr <= '0;
        end else begin
            cmd_code <= nc; cmd_bank <= nb; cmd_addr <= na;
        end
    end

endmodule

// File: rtl/dps_sched_chk.sv
// Protocol checker for dps_sched, bound to every instance. Measures cycles
// between commands with saturating counters and compares them with the
// live timing registers. Assumes timing registers change only while idle.
module dps_sched_chk
    import dps_pkg::*;
#(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    cmd_code,
    input logic          in_sr,
    input logic          miss,
    input logic [TW-1:0] t_rcd,
    input logic [TW-1:0] t_rp,
    input logic [TW-1:0] col_gap
);

    logic [TW-1:0] since_act, since_col, since_pre;
    logic          is_col;

    assign is_col = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);

    // Cycles since the last ACTIVATE, column command and precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '1; since_col <= '1; since_pre <= '1;
        end else begin
            since_act <= (cmd_code == CMD_ACT) ? TW'(1) : (since_act == '1 ? since_act : since_act + 1'b1);
            since_col <= is_col ? TW'(1) : (since_col == '1 ? since_col : since_col + 1'b1);
            since_pre <= (cmd_code == CMD_PRE || cmd_code == CMD_PREA) ? TW'(1)
                         : (since_pre == '1 ? since_pre : since_pre + 1'b1);
        end
    end

    p_act_to_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> since_act >= t_rcd);

    p_col_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> since_col >= col_gap);

    p_ref_after_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_REF) |-> since_pre >= t_rp);

    p_quiet_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sr && $past(in_sr)) |-> cmd_code == CMD_NOP);

    p_miss_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !(cmd_code == CMD_RD || cmd_code == CMD_WR || cmd_code == CMD_ACT));

endmodule

bind dps_sched dps_sched_chk #(.TW(16)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .in_sr(in_self_refresh),
    .miss(miss_flag), .t_rcd(t_rcd), .t_rp(t_rp), .col_gap(col_gap)
);

// File: tb/dps_sched_tb.sv
// Directed bench for dps_sched: one task per scenario, a command log with
// cycle stamps and a scoreboard checking minimum gaps and precharge origin.
module dps_sched_tb;

    localparam int NB = 4;
    localparam int RW = 13;
    localparam int CW = 10;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          sleep_req = 1'b0;
    logic [3:0]    cmd_code;
    logic [BW-1:0] cmd_bank;
    logic [RW-1:0] cmd_addr;
    logic          miss_flag;
    logic          in_self_refresh;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int acc = 0;
    bit done = 1'b0;

    // Mirrors of the timing registers as programmed by the bench
    int m_rcd = 3, m_rp = 3, m_rfc = 8, m_gap = 2;

    // Command log
    int n_log = 0;
    int lg_cmd [256];
    int lg_bank[256];
    int lg_addr[256];
    int lg_cyc [256];

    // Scoreboard state
    int last_act = -1000, last_col = -1000, last_pre = -1000, last_rec = -1000;
    int pre_budget = 0;

    dps_sched #(.NBANK(NB), .ROW_W(RW), .COL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .sleep_req(sleep_req),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .miss_flag(miss_flag), .in_self_refresh(in_self_refresh)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Logs commands at the falling edge and checks gaps and precharge origin.
    always @(negedge clk) begin
        if (rst_n && cmd_code != 4'd0 && n_log < 256) begin
            lg_cmd[n_log] = cmd_code; lg_bank[n_log] = cmd_bank;
            lg_addr[n_log] = cmd_addr; lg_cyc[n_log] = cyc;
            n_log++;
            case (cmd_code)
                4'd1: begin
                    chk(cyc - last_pre >= m_rp, "R3 sb act after pre", cyc - last_pre, m_rp);
                    chk(cyc - last_rec >= m_rfc, "R7 sb act after ref", cyc - last_rec, m_rfc);
                    last_act = cyc;
                end
                4'd2, 4'd3: begin
                    chk(cyc - last_act >= m_rcd, "R1 sb col after act", cyc - last_act, m_rcd);
                    chk(cyc - last_col >= m_gap, "R5 sb col spacing", cyc - last_col, m_gap);
                    last_col = cyc;
                end
                4'd4: begin
                    chk(pre_budget > 0, "R4 sb unrequested precharge", pre_budget, 1);
                    if (pre_budget > 0) pre_budget--;
                    last_pre = cyc;
                end
                4'd5: last_pre = cyc;
                4'd6: begin
                    chk(cyc - last_pre >= m_rp, "R7 sb ref after pre", cyc - last_pre, m_rp);
                    last_rec = cyc;
                end
                4'd8: last_rec = cyc;
                default: ;
            endcase
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cfg(input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        case (idx)
            0: m_rcd = val;
            1: m_rp = val;
            2: m_rfc = val;
            3: m_gap = (val == 0) ? 1 : (val == 1) ? 2 : 4;
            default: ;
        endcase
    endtask

    // Presents one request and returns right after the accepting edge.
    task automatic send(input int op, input int bank, input int row, input int col);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_bank = BW'(bank);
        req_row = RW'(row); req_col = CW'(col);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #0.5;
        acc = cyc;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int find(input int code, input int from);
        for (int i = from; i < n_log; i++)
            if (lg_cmd[i] == code) return i;
        return -1;
    endfunction

    task automatic t_reset();
        chk(cmd_code == 4'd0, "R9 cmd after reset", cmd_code, 0);
        chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
        chk(miss_flag == 1'b0, "R9 miss after reset", miss_flag, 0);
        chk(in_self_refresh == 1'b0, "R9 sleep flag after reset", in_self_refresh, 0);
    endtask

    task automatic t_closed();
        int b = n_log;
        send(0, 0, 5, 7); idle(); wait_cyc(10);
        chk(n_log == b + 2, "R1 entries", n_log - b, 2);
        chk(lg_cmd[b] == 1 && lg_addr[b] == 5, "R1 activate row", lg_addr[b], 5);
        chk(lg_cmd[b+1] == 2 && lg_addr[b+1] == 7, "R1 read column", lg_addr[b+1], 7);
        chk(lg_cyc[b+1] - lg_cyc[b] == 3, "R1 default rcd gap (R6)", lg_cyc[b+1] - lg_cyc[b], 3);
    endtask

    task automatic t_hit();
        int b = n_log;
        send(1, 0, 5, 9); idle(); wait_cyc(6);
        chk(n_log == b + 1, "R2 hit single command", n_log - b, 1);
        chk(lg_cmd[b] == 3 && lg_addr[b] == 9, "R2 write on hit", lg_cmd[b], 3);
        chk(lg_cyc[b] == acc + 1, "R10 hit latency", lg_cyc[b], acc + 1);
    endtask

    task automatic t_stream(input int code, input int op, input int gap, input int cnt);
        int b;
        do_cfg(3, code);
        b = n_log;
        for (int i = 0; i < cnt; i++) send(op, 0, 5, i + 1);
        idle(); wait_cyc(12);
        chk(n_log == b + cnt, "R5 stream entries", n_log - b, cnt);
        for (int i = 1; i < cnt; i++)
            chk(lg_cyc[b+i] - lg_cyc[b+i-1] == gap, "R5 back-to-back gap",
                lg_cyc[b+i] - lg_cyc[b+i-1], gap);
    endtask

    task automatic t_banks();
        int b = n_log;
        send(0, 1, 9, 0); send(0, 0, 5, 1); send(0, 1, 9, 2); idle(); wait_cyc(12);
        chk(n_log == b + 4, "R2 two-bank entries", n_log - b, 4);
        chk(lg_cmd[b] == 1 && lg_bank[b] == 1, "R2 single activate bank1", lg_cmd[b], 1);
        chk(find(1, b + 1) == -1, "R2 no further activate", find(1, b + 1), -1);
        chk(lg_cmd[b+2] == 2 && lg_bank[b+2] == 0, "R2 bank0 still open", lg_bank[b+2], 0);
    endtask

    task automatic t_miss();
        int b = n_log;
        send(0, 0, 6, 4); idle(); wait_cyc(6);
        chk(n_log == b, "R3 miss issues nothing", n_log - b, 0);
        chk(miss_flag == 1'b1, "R3 miss flag", miss_flag, 1);
        pre_budget++;
        send(2, 0, 0, 0); idle(); wait_cyc(12);
        chk(n_log == b + 3, "R3 entries after precharge", n_log - b, 3);
        chk(lg_cmd[b] == 4 && lg_bank[b] == 0, "R3 precharge first", lg_cmd[b], 4);
        chk(lg_cmd[b+1] == 1 && lg_addr[b+1] == 6, "R3 activate new row", lg_addr[b+1], 6);
        chk(lg_cyc[b+1] - lg_cyc[b] == 3, "R3 rp gap", lg_cyc[b+1] - lg_cyc[b], 3);
        chk(lg_cmd[b+2] == 2 && lg_addr[b+2] == 4, "R3 read after", lg_cmd[b+2], 2);
        chk(miss_flag == 1'b0, "R3 miss flag cleared", miss_flag, 0);
    endtask

    task automatic t_precharge();
        int b = n_log;
        send(2, 2, 0, 0); idle(); wait_cyc(6);
        chk(n_log == b, "R4 closed-bank precharge silent", n_log - b, 0);
        chk(req_ready == 1'b1, "R4 request consumed", req_ready, 1);
        pre_budget++;
        send(2, 1, 0, 0); idle(); wait_cyc(6);
        chk(n_log == b + 1 && lg_cmd[b] == 4 && lg_bank[b] == 1, "R4 open-bank precharge",
            lg_bank[b], 1);
    endtask

    task automatic t_cfg();
        int b;
        do_cfg(0, 5);
        b = n_log;
        send(0, 3, 2, 1); idle(); wait_cyc(12);
        chk(lg_cmd[b] == 1 && lg_cmd[b+1] == 2, "R6 act then read", lg_cmd[b+1], 2);
        chk(lg_cyc[b+1] - lg_cyc[b] == 5, "R6 rewritten rcd", lg_cyc[b+1] - lg_cyc[b], 5);
        do_cfg(0, 3);
    endtask

    task automatic t_refresh();
        int b = n_log;
        int r = -1;
        do_cfg(4, 20);
        for (int i = 0; i < 80 && r < 0; i++) begin
            @(negedge clk);
            r = find(6, b);
        end
        do_cfg(4, 60000);
        chk(r > b, "R7 refresh issued", r, b + 1);
        if (r > b) begin
            chk(lg_cmd[r-1] == 5, "R7 precharge-all first", lg_cmd[r-1], 5);
            chk(lg_cyc[r] - lg_cyc[r-1] == 3, "R7 ref after rp", lg_cyc[r] - lg_cyc[r-1], 3);
        end
        b = n_log;
        send(0, 0, 6, 3); idle(); wait_cyc(12);
        chk(lg_cmd[b] == 1 && lg_addr[b] == 6, "R7 rows closed after refresh", lg_cmd[b], 1);
        if (r > 0)
            chk(lg_cyc[b] - lg_cyc[r] >= 8, "R7 rfc respected", lg_cyc[b] - lg_cyc[r], 8);
    endtask

    task automatic t_sleep();
        int b = n_log;
        int s, x;
        sleep_req = 1'b1;
        wait_cyc(10);
        s = find(7, b);
        chk(s == b + 1 && lg_cmd[b] == 5, "R8 close then enter", s, b + 1);
        chk(in_self_refresh == 1'b1, "R8 in self-refresh", in_self_refresh, 1);
        send(0, 3, 2, 5); send(0, 3, 2, 6); idle();
        chk(req_ready == 1'b0, "R11 ready low with two held", req_ready, 0);
        wait_cyc(10);
        chk(n_log == b + 2, "R8 blocked while asleep", n_log - b, 2);
        sleep_req = 1'b0;
        wait_cyc(25);
        x = find(8, b);
        chk(x == b + 2, "R8 exit issued", x, b + 2);
        chk(in_self_refresh == 1'b0, "R8 flag cleared", in_self_refresh, 0);
        chk(lg_cmd[b+3] == 1 && lg_cyc[b+3] - lg_cyc[b+2] == 8, "R8 activate after rfc",
            lg_cyc[b+3] - lg_cyc[b+2], 8);
        chk(lg_cmd[b+5] == 2 && lg_addr[b+5] == 6, "R11 second held request served",
            lg_addr[b+5], 6);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cmd_code == 4'd0, "R9 cmd during reset", cmd_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        do_cfg(4, 60000);
        t_closed();
        t_hit();
        t_stream(1, 0, 2, 3);
        t_stream(2, 1, 4, 2);
        t_stream(0, 0, 1, 3);
        do_cfg(3, 1);
        t_banks();
        t_miss();
        t_precharge();
        t_cfg();
        t_refresh();
        t_sleep();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        report();
    end

endmodule